// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address through a two-level page table, with 1 KB pages. The page number is itself paged. The top 12 bits of the logical address select a word in an outer table. That word locates an inner table. The next 10 bits select a word in the inner table, and that word holds the physical frame. The low 10 bits pass through unchanged as the byte offset within the page.

A requester presents a logical address with a valid/ready handshake. The walker samples the root table base at the same moment. It then makes two dependent reads through one memory read port, one read for each level. The memory port has no backpressure: a read is a one-cycle request pulse, and data returns later with a valid strobe. Each walk ends in a one-cycle response. The response carries either the translated address or a fault that names the level whose entry was not valid. Only one walk is in progress at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle. `reqReady` is 1, and `rspValid` and `memReqValid` are 0.
- R2: The first read after a request is accepted goes to `rootBase + 4 * reqLogAddr[31:20]`.
- R3: The second read goes to `{outerEntry[31:10], 10'b0} + 4 * reqLogAddr[19:10]`. Bits 9:1 of the outer entry are ignored.
- R4: A table entry is valid when its bit 0 is 1, and bits 31:10 hold the frame number. When both entries are valid, the response has `rspFault`=0 and `rspPhysAddr = {innerEntry[31:10], reqLogAddr[9:0]}`.
- R5: If the outer entry has bit 0 = 0, the walk makes exactly one read. It then responds with `rspFault`=1 and `rspFaultLevel`=0 (outer level).
- R6: If the inner entry has bit 0 = 0, the walk makes exactly two reads. It then responds with `rspFault`=1 and `rspFaultLevel`=1 (inner level).
- R7: `reqReady` stays 0 from the acceptance of a request until its response. A `reqValid` held during that window starts no walk and produces no response.
- R8: Each read is a single-cycle `memReqValid` pulse. No new read is issued while a read awaits `memRspValid`.
- R9: Every accepted request produces exactly one response, and `rspValid` lasts one cycle. `reqReady` is 1 in the cycle after the response.
- R10: `rootBase` is sampled when the request is accepted. Later changes to `rootBase` do not affect the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to accept |
| reqLogAddr | input | 32 | Logical address to translate |
| rootBase | input | 32 | Base address of the outer table |
| rspValid | output | 1 | One-cycle response strobe |
| rspPhysAddr | output | 32 | Translated physical address |
| rspFault | output | 1 | Translation failed |
| rspFaultLevel | output | 1 | Level that failed: 0 outer, 1 inner |
| memReqValid | output | 1 | Read request pulse |
| memReqAddr | output | 32 | Read address |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | Returned table entry |

## Verification
The checker watches every cycle for several properties:
- the handshake discipline: no acceptance while busy, a single outstanding read, and a one-cycle response followed by a return to ready;
- the first-level read address;
- the number of reads behind each response type;
- the offset passthrough on success.

The second-level address, the frame substitution, the masking of the outer entry's low bits, the sampling of `rootBase`, and the rejection of requests held during a walk are shown only by bench scenarios. Those scenarios use a memory model with varied latency, entries set up per case, and a mid-walk change to `rootBase` while `reqValid` is held.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_L1_REQ,
    S_L1_WAIT,
    S_L2_REQ,
    S_L2_WAIT,
    S_DONE
  } walkState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureReq;    // latch logical address and root base
    logic captureInner;  // latch inner table base from outer entry
    logic finishOk;      // latch translated address
    logic finishFault;   // latch fault result
    logic faultLevel;    // 0 outer, 1 inner
    logic useInner;      // address mux selects second-level read
  } walkStrobes_t;

endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memRspValid,
  input  logic         entryValid,
  output logic         reqReady,
  output logic         memReqValid,
  output logic         rspValid,
  output walkStrobes_t stb
);

  walkState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    stb         = '0;
    reqReady    = (state == S_IDLE);
    memReqValid = (state == S_L1_REQ) || (state == S_L2_REQ);
    rspValid    = (state == S_DONE);
    stb.useInner = (state == S_L2_REQ) || (state == S_L2_WAIT);
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.captureReq = 1'b1;
          stateNext      = S_L1_REQ;
        end
      end
      S_L1_REQ:  stateNext = S_L1_WAIT;
      S_L1_WAIT: begin
        if (memRspValid) begin
          if (entryValid) begin
            stb.captureInner = 1'b1;
            stateNext        = S_L2_REQ;
          end else begin
            stb.finishFault = 1'b1;
            stb.faultLevel  = 1'b0;
            stateNext       = S_DONE;
          end
        end
      end
      S_L2_REQ:  stateNext = S_L2_WAIT;
      S_L2_WAIT: begin
        if (memRspValid) begin
          if (entryValid) begin
            stb.finishOk = 1'b1;
          end else begin
            stb.finishFault = 1'b1;
            stb.faultLevel  = 1'b1;
          end
          stateNext = S_DONE;
        end
      end
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFFSET_W  = 10,
  parameter int INNER_W   = 10,
  parameter int PTE_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobes_t      stb,
  input  logic [ADDR_W-1:0] reqLogAddr,
  input  logic [ADDR_W-1:0] rootBase,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              entryValid,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] rspPhysAddr,
  output logic              rspFault,
  output logic              rspFaultLevel
);

  localparam int OUTER_W = ADDR_W - OFFSET_W - INNER_W;
  localparam int FRAME_W = ADDR_W - OFFSET_W;

  logic [ADDR_W-1:0]  vaddrQ, rootQ, innerBaseQ;
  logic [OUTER_W-1:0] outerIdx;
  logic [INNER_W-1:0] innerIdx;
  logic [FRAME_W-1:0] entryFrame;
  logic [ADDR_W-1:0]  l1Addr, l2Addr;

  assign outerIdx   = vaddrQ[ADDR_W-1 -: OUTER_W];
  assign innerIdx   = vaddrQ[OFFSET_W +: INNER_W];
  assign entryFrame = memRspData[ADDR_W-1 -: FRAME_W];
  assign entryValid = memRspData[0];

  assign l1Addr     = rootQ + (ADDR_W'(outerIdx) << PTE_SHIFT);
  assign l2Addr     = innerBaseQ + (ADDR_W'(innerIdx) << PTE_SHIFT);
  assign memReqAddr = stb.useInner ? l2Addr : l1Addr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ        <= '0;
      rootQ         <= '0;
      innerBaseQ    <= '0;
      rspPhysAddr   <= '0;
      rspFault      <= 1'b0;
      rspFaultLevel <= 1'b0;
    end else begin
      if (stb.captureReq) begin
        vaddrQ <= reqLogAddr;
        rootQ  <= rootBase;
      end
      if (stb.captureInner) innerBaseQ <= {entryFrame, {OFFSET_W{1'b0}}};
      if (stb.finishOk) begin
        rspPhysAddr   <= {entryFrame, vaddrQ[OFFSET_W-1:0]};
        rspFault      <= 1'b0;
        rspFaultLevel <= 1'b0;
      end else if (stb.finishFault) begin
        rspPhysAddr   <= '0;
        rspFault      <= 1'b1;
        rspFaultLevel <= stb.faultLevel;
      end
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFFSET_W  = 10,
  parameter int INNER_W   = 10,
  parameter int PTE_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqLogAddr,
  input  logic [ADDR_W-1:0] rootBase,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPhysAddr,
  output logic              rspFault,
  output logic              rspFaultLevel,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData
);

  walkStrobes_t stb;
  logic         entryValid;

  pt_walker_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .entryValid  (entryValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .rspValid    (rspValid),
    .stb         (stb)
  );

  pt_walker_dp #(
    .ADDR_W    (ADDR_W),
    .OFFSET_W  (OFFSET_W),
    .INNER_W   (INNER_W),
    .PTE_SHIFT (PTE_SHIFT)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .reqLogAddr    (reqLogAddr),
    .rootBase      (rootBase),
    .memRspData    (memRspData),
    .entryValid    (entryValid),
    .memReqAddr    (memReqAddr),
    .rspPhysAddr   (rspPhysAddr),
    .rspFault      (rspFault),
    .rspFaultLevel (rspFaultLevel)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W    = 32,
  parameter int OFFSET_W  = 10,
  parameter int INNER_W   = 10,
  parameter int PTE_SHIFT = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqLogAddr,
  input logic [ADDR_W-1:0] rootBase,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspPhysAddr,
  input logic              rspFault,
  input logic              rspFaultLevel,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic [ADDR_W-1:0] memRspData
);

  localparam int OUTER_W = ADDR_W - OFFSET_W - INNER_W;

  logic              busy, outstanding;
  logic [1:0]        readCnt;
  logic [ADDR_W-1:0] addrLat, rootLat, expL1;

  assign expL1 = rootLat + (ADDR_W'(addrLat[ADDR_W-1 -: OUTER_W]) << PTE_SHIFT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy        <= 1'b0;
      outstanding <= 1'b0;
      readCnt     <= '0;
      addrLat     <= '0;
      rootLat     <= '0;
    end else begin
      if (reqValid && reqReady) begin
        busy    <= 1'b1;
        readCnt <= '0;
        addrLat <= reqLogAddr;
        rootLat <= rootBase;
      end else if (memReqValid && readCnt != 2'd3) begin
        readCnt <= readCnt + 2'd1;
      end
      if (rspValid) busy <= 1'b0;
      if (memReqValid)      outstanding <= 1'b1;
      else if (memRspValid) outstanding <= 1'b0;
    end
  end

  a_r7_not_ready_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady);

  a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !outstanding);

  a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  a_r9_rsp_pulse_then_ready: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  a_r2_first_read_addr: assert property (@(posedge clk) disable iff (!rstN)
    (busy && memReqValid && readCnt == 2'd0) |-> memReqAddr == expL1);

  a_r5_outer_fault_one_read: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault && !rspFaultLevel) |-> readCnt == 2'd1);

  a_r6_inner_fault_two_reads: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault && rspFaultLevel) |-> readCnt == 2'd2);

  a_r4_offset_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |->
      (readCnt == 2'd2 && rspPhysAddr[OFFSET_W-1:0] == addrLat[OFFSET_W-1:0]));

endmodule

bind pt_walker pt_walker_chk #(
  .ADDR_W    (ADDR_W),
  .OFFSET_W  (OFFSET_W),
  .INNER_W   (INNER_W),
  .PTE_SHIFT (PTE_SHIFT)
) u_chk (.*);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqLogAddr = '0;
  logic [31:0] rootBase = '0;
  logic        rspValid;
  logic [31:0] rspPhysAddr;
  logic        rspFault;
  logic        rspFaultLevel;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  always #4 clk = ~clk;  // 125 MHz

  pt_walker u_dut (.*);

  typedef struct {
    logic [31:0] phys;
    logic        fault;
    logic        lvl;
    int          nReads;
    logic [31:0] a1;
    logic [31:0] a2;
  } expItem_t;

  expItem_t    expQ[$];
  logic [31:0] readLog[$];
  logic [31:0] mem[logic [31:0]];
  int          memLat = 1;
  int          testCnt = 0;
  int          failCnt = 0;
  bit          finished = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model: responds memLat cycles after the request, logs read addresses
  initial begin
    int cnt = 0;
    logic [31:0] pend = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          memRspValid = 1'b1;
          memRspData  = rd(pend);
        end
      end
      if (memReqValid) begin
        pend = memReqAddr;
        cnt  = memLat;
        readLog.push_back(memReqAddr);
      end
    end
  end

  // monitor: compares each response with the oldest expected item
  initial begin
    forever begin
      @(negedge clk);
      if (rspValid) begin
        if (expQ.size() == 0) begin
          check("R7 unexpected response", 32'd1, 32'd0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check("R4/R5/R6 fault flag", 32'(rspFault), 32'(e.fault));
          if (e.fault) check("R5/R6 fault level", 32'(rspFaultLevel), 32'(e.lvl));
          else         check("R4 physical address", rspPhysAddr, e.phys);
          check("R5/R6/R8 read count", 32'(readLog.size()), 32'(e.nReads));
          if (readLog.size() > 0) check("R2 outer read addr", readLog[0], e.a1);
          if (readLog.size() > 1 && e.nReads > 1) check("R3 inner read addr", readLog[1], e.a2);
        end
        readLog.delete();
        @(negedge clk);
        check("R9 response one cycle", 32'(rspValid), 32'd0);
        check("R9 ready after response", 32'(reqReady), 32'd1);
      end
    end
  end

  // driver: computes expectation from the table contents, then issues the request
  task automatic walk(input logic [31:0] va, input logic [31:0] root,
                      input bit poke, input bit moveRoot);
    expItem_t e;
    logic [31:0] ent1, ent2;
    e.a1   = root + ({20'd0, va[31:20]} << 2);
    ent1   = rd(e.a1);
    e.a2   = '0;
    e.phys = '0;
    e.lvl  = 1'b0;
    if (!ent1[0]) begin
      e.fault = 1'b1; e.lvl = 1'b0; e.nReads = 1;
    end else begin
      e.a2 = {ent1[31:10], 10'd0} + ({22'd0, va[19:10]} << 2);
      ent2 = rd(e.a2);
      e.nReads = 2;
      if (!ent2[0]) begin
        e.fault = 1'b1; e.lvl = 1'b1;
      end else begin
        e.fault = 1'b0; e.phys = {ent2[31:10], va[9:0]};
      end
    end
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    expQ.push_back(e);
    reqValid   = 1'b1;
    reqLogAddr = va;
    rootBase   = root;
    @(negedge clk);
    if (poke || moveRoot) begin
      if (moveRoot) rootBase = root ^ 32'h5555_0000;
      if (poke) begin
        reqLogAddr = ~va;
        check("R7 not ready while busy", 32'(reqReady), 32'd0);
        @(negedge clk);
        check("R7 still not ready", 32'(reqReady), 32'd0);
      end
    end
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    // table setup
    mem[32'h0010_0000 + (32'h123 << 2)] = 32'h0020_0001;
    mem[32'h0020_0000 + (32'h115 << 2)] = 32'hABCD_E401;
    mem[32'h0010_0000 + (32'hFFF << 2)] = 32'h0030_03FF;  // low junk bits (R3)
    mem[32'h0030_0000 + (32'h3FF << 2)] = 32'h1234_5C01;
    mem[32'h0010_0000]                  = 32'h0040_0001;
    mem[32'h0040_0000]                  = 32'h0000_0401;
    mem[32'h0010_0000 + (32'h200 << 2)] = 32'h0050_0001;
    mem[32'h0050_0000 + (32'h001 << 2)] = 32'hFFFF_FC00;  // inner invalid (R6)
    mem[32'h0800_0000 + (32'h123 << 2)] = 32'h0060_0001;
    mem[32'h0060_0000 + (32'h115 << 2)] = 32'h0BAD_0001;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset ready",      32'(reqReady),    32'd1);
    check("R1 reset rspValid",   32'(rspValid),    32'd0);
    check("R1 reset memReq",     32'(memReqValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 32'(reqReady),    32'd1);

    memLat = 1;
    walk(32'h1234_5678, 32'h0010_0000, 0, 0);  // R4 success
    walk(32'hFFFF_FFFF, 32'h0010_0000, 0, 0);  // R3 masked base, top indices
    walk(32'h0000_03AB, 32'h0010_0000, 0, 0);  // zero indices
    walk(32'h7770_0000, 32'h0010_0000, 0, 0);  // R5 outer invalid
    walk(32'h2000_07FF, 32'h0010_0000, 0, 0);  // R6 inner invalid
    memLat = 5;
    walk(32'h1234_5678, 32'h0010_0000, 1, 1);  // R7 poke, R10 root change
    walk(32'h1234_5ABC, 32'h0800_0000, 0, 0);  // other root
    walk(32'h0010_0000, 32'h0800_0000, 0, 0);  // R5 under alternate root
    memLat = 3;
    walk(32'h2000_0400, 32'h0010_0000, 1, 0);  // R6 with poke
    walk(32'hFFFF_FC00, 32'h0010_0000, 0, 1);  // R10 with R3

    @(negedge clk);
    while (expQ.size() != 0 || !reqReady) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R9 all responses seen", 32'(expQ.size()), 32'd0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule